// File: doc/BRIEF.md
# Low-Storage Protection Checker and Prefix Mapper

This block sits next to the storage access path of a processor. It takes a real address, the kind of access (load, store or instruction fetch) and a handful of control inputs. For each access it works out three things. First, whether a store has to be refused because it hits the protected low storage. Second, whether the page must be flagged so that a cached write permission for it is not reused. Third, the exception code that goes with the access.

The block also turns the real address into an absolute address by prefixing. The first 8 KiB of real storage and an 8 KiB area chosen by a prefix register swap places in both directions.

The protected storage is two separate 512-byte windows, one at the start of each of the first two 4 KiB pages. Protection is switched on by an enable input. It always applies while address translation is off. While translation is on, it applies only when the private-space bit of the selected address-space descriptor is clear.

All results are registered and appear one cycle after an input strobe, together with a matching valid output.

Top module: `lap_prefix_guard`

## Requirements
- R1: An address counts as protected exactly when it lies in 0..511 or in 4096..4607, both bounds included.
- R2: Protection is active only when `lap_en` is 1. It is then active when `dat_on` is 0, or when `dat_on` is 1 and `priv_space` is 0. It is inactive when `lap_en` is 1, `dat_on` is 1 and `priv_space` is 1.
- R3: `out_reject` is 1 only for a store (`in_acc` = 2'b01) to a protected address while protection is active. Loads (2'b00), fetches (2'b10) and the unused code 2'b11 are never rejected.
- R4: `out_wr_inv` is 1 when protection is active and the address, rounded down to a 4 KiB boundary, is protected. With 4 KiB pages this means any address below 0x2000. This holds for every access type.
- R5: `out_exc_code` is the address with its low 12 bits cleared, ORed with two values. The first is 0x400 for a store, or 0x800 for any other access code. The second is 0x80 when the access is rejected.
- R6: `out_abs_addr` equals the real address plus the aligned prefix when the real address is below 0x2000.
- R7: When the real address lies in [P, P+0x2000), `out_abs_addr` equals the real address minus P. P is the aligned prefix. This case applies only when the real address is not below 0x2000.
- R8: All other addresses pass to `out_abs_addr` unchanged. The low 13 bits of `prefix` are ignored, so the aligned prefix P is `prefix` with bits 12..0 cleared.
- R9: Results appear on the outputs one clock edge after the edge that samples `in_valid` = 1, and `out_valid` is 1 for exactly that cycle. While `in_valid` is 0, `out_valid` falls to 0 and the data outputs hold their values whatever the other inputs do.
- R10: While `rst_n` is 0 at a clock edge, every output is cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: sample the access inputs at this edge |
| in_addr | input | ADDR_W | Real address of the access |
| in_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 treated as a load |
| lap_en | input | 1 | Low-storage protection enable |
| dat_on | input | 1 | Address translation is on |
| priv_space | input | 1 | Private-space bit of the selected address-space descriptor |
| prefix | input | ADDR_W | Prefix register; bits 12..0 ignored |
| out_valid | output | 1 | Results below belong to the last strobe |
| out_reject | output | 1 | Store refused by low-storage protection |
| out_wr_inv | output | 1 | Do not reuse a cached write permission for this page |
| out_exc_code | output | ADDR_W | Exception code for the access |
| out_abs_addr | output | ADDR_W | Absolute address after prefixing |

## Verification
Suppose the window decode were off by one at 511/512 or 4607/4608. Then a store just inside or just outside a window would show the wrong `out_reject` and the wrong 0x80 bit in `out_exc_code`. That would be seen in the cycle after the strobe. A broken enable rule shows up in the same cycle, as wrong reject and write-invalidate flags for one of the `lap_en`/`dat_on`/`priv_space` combinations.

Mapping faults show in `out_abs_addr` one cycle after the strobe. Examples are a bad range compare at P-1, P, P+0x1FFF or P+0x2000, or prefix bits 12..0 leaking into the result. A bad output register shows as `out_valid` staying high, or as data that changes when `in_valid` is 0 and the address inputs are moved.

// File: rtl/lap_pkg.sv
`timescale 1ns/1ps
// Package: shared access-kind encoding and fixed geometry of the low-storage checker.
package lap_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    // Size of the swapped low area is 2**SWAP_BITS bytes.
    localparam int SWAP_BITS  = 13;
    // Page size is 2**PAGE_BITS bytes.
    localparam int PAGE_BITS  = 12;
    // Exception code flag values.
    localparam int EXC_STORE  = 'h400;
    localparam int EXC_READ   = 'h800;
    localparam int EXC_LAP    = 'h80;
endpackage

// File: rtl/lap_window.sv
`timescale 1ns/1ps
// Module: lap_window
// Flags an address that falls in one of NUM_WIN protected windows. Window k
// starts at byte k * 2**PAGE_BITS and is WIN_BYTES long.
// Assumes WIN_BYTES <= 2**PAGE_BITS and NUM_WIN < 2**(ADDR_W-PAGE_BITS).
module lap_window #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int WIN_BYTES = 512,
    parameter int NUM_WIN   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int HI_W = ADDR_W - PAGE_BITS;

    logic [NUM_WIN-1:0] win_hit;

    // One comparator per window: same page number and offset below the window size.
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        assign win_hit[k] = (addr[ADDR_W-1:PAGE_BITS] == HI_W'(k)) &&
                            (addr[PAGE_BITS-1:0] < PAGE_BITS'(WIN_BYTES));
    end

    assign hit = |win_hit;

    // Guard: a hit is never reported beyond the last window's page.
    always_comb begin
        if (hit) begin
            assert_window_bound_R1: assert (addr[ADDR_W-1:PAGE_BITS] < HI_W'(NUM_WIN));
        end
    end
endmodule

// File: rtl/lap_prefix_map.sv
`timescale 1ns/1ps
// Module: lap_prefix_map
// Converts a real address to an absolute address. The low 2**SWAP_BITS bytes
// and the prefix area of the same size trade places; every other address
// passes through unchanged. The prefix is treated as aligned: its low
// SWAP_BITS bits are discarded.
module lap_prefix_map #(
    parameter int ADDR_W    = 32,
    parameter int SWAP_BITS = 13
) (
    input  logic [ADDR_W-1:0] raddr,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << SWAP_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] pfx_al;
    logic              in_low;
    logic              in_pfx;

    // Drop the ignored low bits of the prefix.
    assign pfx_al = prefix & ALIGN_MASK;
    // Address lies in the low area.
    assign in_low = (raddr[ADDR_W-1:SWAP_BITS] == '0);
    // Address lies in the aligned prefix area.
    assign in_pfx = (raddr[ADDR_W-1:SWAP_BITS] == pfx_al[ADDR_W-1:SWAP_BITS]);

    // Select the swapped or unchanged address; the low area takes precedence.
    always_comb begin
        if (in_low) begin
            abs_addr = raddr + pfx_al;
        end else if (in_pfx) begin
            abs_addr = raddr - pfx_al;
        end else begin
            abs_addr = raddr;
        end
    end

    // Guard: the low area always lands inside the prefix area, keeping its offset.
    always_comb begin
        if (in_low) begin
            assert_low_lands_in_prefix_R6: assert (
                abs_addr[ADDR_W-1:SWAP_BITS] == pfx_al[ADDR_W-1:SWAP_BITS] &&
                abs_addr[SWAP_BITS-1:0] == raddr[SWAP_BITS-1:0]);
        end
    end
endmodule

// File: rtl/lap_exc_code.sv
`timescale 1ns/1ps
// Module: lap_exc_code
// Builds the exception code: the page-aligned address, a store-or-read flag
// and a protection flag. Assumes PAGE_BITS >= 12 so the flags fit below the
// page number.
module lap_exc_code
    import lap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_store,
    input  logic              rejected,
    output logic [ADDR_W-1:0] code
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

    // Merge the aligned address with the access flags.
    always_comb begin
        code = addr & PAGE_MASK;
        code = code | (is_store ? ADDR_W'(EXC_STORE) : ADDR_W'(EXC_READ));
        if (rejected) begin
            code = code | ADDR_W'(EXC_LAP);
        end
    end
endmodule

// File: rtl/lap_prefix_guard.sv
`timescale 1ns/1ps
// Module: lap_prefix_guard (top)
// Low-storage protection check plus prefix mapping for one access per strobe.
// Every result is registered and shows up one cycle after in_valid, with
// out_valid high for that cycle. The data outputs hold between strobes.
// Assumes a 4 KiB page, so an aligned address below 0x2000 is always protected.
module lap_prefix_guard
    import lap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_acc,
    input  logic              lap_en,
    input  logic              dat_on,
    input  logic              priv_space,
    input  logic [ADDR_W-1:0] prefix,
    output logic              out_valid,
    output logic              out_reject,
    output logic              out_wr_inv,
    output logic [ADDR_W-1:0] out_exc_code,
    output logic [ADDR_W-1:0] out_abs_addr
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

    logic              prot_active;
    logic              is_store;
    logic              byte_hit;
    logic              page_hit;
    logic              reject_c;
    logic              wr_inv_c;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] code_c;
    logic [ADDR_W-1:0] abs_c;

    // Protection enable: always on without translation, else only when not private.
    assign prot_active = lap_en && (!dat_on || !priv_space);
    // Store decode: only the store code counts as a write.
    assign is_store    = (acc_t'(in_acc) == ACC_STORE);
    // Page-aligned view of the address for the write-invalidate test.
    assign page_addr   = in_addr & PAGE_MASK;

    lap_window #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_BYTES(WIN_BYTES), .NUM_WIN(2)
    ) u_byte_win (
        .addr(in_addr),
        .hit (byte_hit)
    );

    lap_window #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_BYTES(WIN_BYTES), .NUM_WIN(2)
    ) u_page_win (
        .addr(page_addr),
        .hit (page_hit)
    );

    // Decide rejection and write invalidation from the window hits.
    assign reject_c = prot_active && is_store && byte_hit;
    assign wr_inv_c = prot_active && page_hit;

    lap_exc_code #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
    ) u_exc (
        .addr    (in_addr),
        .is_store(is_store),
        .rejected(reject_c),
        .code    (code_c)
    );

    lap_prefix_map #(
        .ADDR_W(ADDR_W), .SWAP_BITS(SWAP_BITS)
    ) u_map (
        .raddr   (in_addr),
        .prefix  (prefix),
        .abs_addr(abs_c)
    );

    // Output stage: capture the results on a strobe and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_reject   <= 1'b0;
            out_wr_inv   <= 1'b0;
            out_exc_code <= '0;
            out_abs_addr <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_reject   <= reject_c;
                out_wr_inv   <= wr_inv_c;
                out_exc_code <= code_c;
                out_abs_addr <= abs_c;
            end
        end
    end

    // A strobe produces a valid result one cycle later.
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // Without a strobe the results hold and valid drops.
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_exc_code) && $stable(out_abs_addr)));

    // A rejected store always also marks the page for write invalidation.
    assert_reject_implies_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_reject |-> out_wr_inv);

    // The protection flag in the code agrees with the reject output.
    assert_code_flag_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_exc_code[7] == out_reject));

    // A rejected access carries the store flag, never the read flag.
    assert_reject_is_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_reject |-> (out_exc_code[10] && !out_exc_code[11]));

    // Reset clears the valid output.
    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/tb_lap_prefix_guard.sv
`timescale 1ns/1ps
// Bench: sweeps boundary addresses, all access codes, all control
// combinations and several prefixes, and compares against arithmetic models.
module tb_lap_prefix_guard;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [1:0]    in_acc = '0;
    logic          lap_en = 1'b0;
    logic          dat_on = 1'b0;
    logic          priv_space = 1'b0;
    logic [AW-1:0] prefix = '0;
    logic          out_valid, out_reject, out_wr_inv;
    logic [AW-1:0] out_exc_code, out_abs_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    lap_prefix_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_acc(in_acc), .lap_en(lap_en), .dat_on(dat_on), .priv_space(priv_space),
        .prefix(prefix), .out_valid(out_valid), .out_reject(out_reject),
        .out_wr_inv(out_wr_inv), .out_exc_code(out_exc_code), .out_abs_addr(out_abs_addr)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (addr %h acc %0d en %0d dat %0d priv %0d pfx %h)",
                     req, act, exp, in_addr, in_acc, lap_en, dat_on, priv_space, prefix);
        end
    endtask

    function automatic bit m_prot(input logic [AW-1:0] a);
        return (a <= 511) || (a >= 4096 && a <= 4607);
    endfunction

    function automatic logic [AW-1:0] m_abs(input logic [AW-1:0] a, input logic [AW-1:0] p);
        logic [63:0] pm;
        pm = {32'b0, p & 32'hFFFF_E000};
        if (a < 32'h2000) return a + pm[31:0];
        if ({32'b0, a} >= pm && {32'b0, a} < pm + 64'h2000) return a - pm[31:0];
        return a;
    endfunction

    task automatic apply_and_check(input logic [AW-1:0] a, input logic [1:0] acc,
                                   input bit en, input bit dat, input bit pv,
                                   input logic [AW-1:0] p, input bit hold_chk);
        bit act_on, st, rej, inv;
        logic [AW-1:0] code, absx;
        act_on = en && (!dat || !pv);
        st     = (acc == 2'b01);
        rej    = act_on && st && m_prot(a);
        inv    = act_on && m_prot(a & 32'hFFFF_F000);
        code   = (a & 32'hFFFF_F000) | (st ? 32'h400 : 32'h800) | (rej ? 32'h80 : 32'h0);
        absx   = m_abs(a, p);
        @(negedge clk);
        in_addr = a; in_acc = acc; lap_en = en; dat_on = dat; priv_space = pv; prefix = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 out_valid", {63'b0, out_valid}, 64'd1);
        chk("R1/R2/R3 reject", {63'b0, out_reject}, {63'b0, rej});
        chk("R4 wr_inv", {63'b0, out_wr_inv}, {63'b0, inv});
        chk("R5 exc_code", {32'b0, out_exc_code}, {32'b0, code});
        chk("R6/R7/R8 abs_addr", {32'b0, out_abs_addr}, {32'b0, absx});
        if (hold_chk) begin
            in_addr = ~a; in_acc = ~acc; prefix = ~p;
            @(negedge clk);
            chk("R9 idle valid", {63'b0, out_valid}, 64'd0);
            chk("R9 idle hold code", {32'b0, out_exc_code}, {32'b0, code});
            chk("R9 idle hold abs", {32'b0, out_abs_addr}, {32'b0, absx});
        end
    endtask

    initial begin
        logic [AW-1:0] pfx_list [4];
        logic [AW-1:0] base_list [12];
        pfx_list[0] = 32'h0000_0000;
        pfx_list[1] = 32'h0000_4000;
        pfx_list[2] = 32'h0012_3FFF;   // low 13 bits set: must be ignored (R8)
        pfx_list[3] = 32'hFFFF_E000;
        base_list[0] = 0;    base_list[1] = 1;    base_list[2] = 511;
        base_list[3] = 512;  base_list[4] = 4095; base_list[5] = 4096;
        base_list[6] = 4607; base_list[7] = 4608; base_list[8] = 8191;
        base_list[9] = 8192; base_list[10] = 32'h0000_3010; base_list[11] = 32'h8765_4321;

        repeat (3) @(negedge clk);
        // R10: outputs clear under reset.
        chk("R10 valid", {63'b0, out_valid}, 64'd0);
        chk("R10 reject", {63'b0, out_reject}, 64'd0);
        chk("R10 wr_inv", {63'b0, out_wr_inv}, 64'd0);
        chk("R10 code", {32'b0, out_exc_code}, 64'd0);
        chk("R10 abs", {32'b0, out_abs_addr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {63'b0, out_valid}, 64'd0);

        for (int pi = 0; pi < 4; pi++) begin
            logic [AW-1:0] pa;
            logic [AW-1:0] addrs [18];
            pa = pfx_list[pi] & 32'hFFFF_E000;
            for (int b = 0; b < 12; b++) addrs[b] = base_list[b];
            addrs[12] = pa - 1;     addrs[13] = pa;
            addrs[14] = pa + 5;     addrs[15] = pa + 32'h1FFF;
            addrs[16] = pa + 32'h2000; addrs[17] = pa + 32'h1200;
            for (int ai = 0; ai < 18; ai++) begin
                for (int acc = 0; acc < 4; acc++) begin
                    for (int c = 0; c < 8; c++) begin
                        apply_and_check(addrs[ai], 2'(acc), c[2], c[1], c[0],
                                        pfx_list[pi], (c == 7) || (acc == 1 && c == 4));
                    end
                end
            end
        end

        // Back-to-back strobes: each result lands one cycle after its strobe (R9).
        @(negedge clk);
        in_acc = 2'b01; lap_en = 1'b1; dat_on = 1'b0; priv_space = 1'b0; prefix = 32'h4000;
        in_addr = 32'd100; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 b2b first reject", {63'b0, out_reject}, 64'd1);
        in_addr = 32'd600;
        @(negedge clk);
        chk("R9 b2b second reject", {63'b0, out_reject}, 64'd0);
        chk("R9 b2b second valid", {63'b0, out_valid}, 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 b2b drop", {63'b0, out_valid}, 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule